// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank SDRAM. It drives the command pins, the address bus and the clock enable. Its job is to bring the memory out of power-up and then keep its rows refreshed. After reset it holds the bus idle for a programmable pause. It then closes every bank, issues a configurable burst of auto-refresh commands with the row cycle time between them, and writes the mode register. It raises `ready` once the mode-set settling time has passed.

After that point a free-running interval timer adds one owed refresh for every refresh interval. By default the interval is the clock count that gives 4096 refreshes per 64 ms. While any refresh is owed and the sequencer is idle, `ref_req` is high. The user's access logic answers with `ref_gnt` when it has released the bus. The sequencer then closes all banks and issues the owed refreshes, holding `ref_busy` high until the last refresh has had its full row cycle time. The owed count saturates at two. If the user lets more than one interval pass without a grant, the grant produces two refreshes back to back, which catches the memory up.

All timing values (pause, precharge time, row cycle time, mode-set settling time) are parameters in clock cycles, and each must be at least 2. Data transfers and self-refresh do not belong to this block.

Top module: `sdr_init_refresh`

## Requirements
- R1: While `rst_n` is low, the command pins show NOP, `sd_cke` is low, and `ready`, `ref_req` and `ref_busy` are low.
- R2: The command code {cs_n,ras_n,cas_n,we_n} is 0111 for NOP, 0010 for precharge, 0001 for auto-refresh and 0000 for mode-register set. After reset is released, only NOP appears for PAUSE_CYC cycles. The first command is then a precharge-all with address bit 10 set and every other address bit clear.
- R3: The first auto-refresh of initialization comes T_RP cycles after the precharge-all. Exactly INIT_REFS auto-refreshes are issued, T_RC cycles apart, with address zero.
- R4: The mode-register set comes T_RC cycles after the last initialization refresh and carries MODE_WORD on the address. `sd_cke` is high in the cycle before it, and the cycle after it is a NOP.
- R5: `ready` rises T_MRD cycles after the mode-register set and stays high until the next reset.
- R6: Any command that follows an auto-refresh comes at least T_RC cycles after it.
- R7: An auto-refresh is issued only when the most recent earlier command was a precharge or an auto-refresh, so every bank is closed.
- R8: `ref_req` first rises REF_CYC cycles after `ready` rises, and the interval timer then runs freely with period REF_CYC. `ref_req` is only ever high while `ready` is high, and it stays high until it is granted.
- R9: If `ref_req` and `ref_gnt` are both high at a clock edge, a precharge-all follows at that edge and an auto-refresh follows T_RP cycles later. `ref_busy` is high from the precharge until T_RC cycles after the last refresh, and `ref_req` is low during that time.
- R10: The owed refresh count saturates at 2. When two or more intervals have elapsed without a grant, one grant produces exactly two auto-refreshes, T_RC cycles apart.
- R11: `ref_gnt` has no effect while `ref_req` is low: no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action happens on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | User permission to take the bus for refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (precharge-all flag, mode word) |
| sd_cke | output | 1 | Clock enable to the memory |
| ready | output | 1 | Initialization complete |
| ref_req | output | 1 | A refresh is owed and the sequencer is idle |
| ref_busy | output | 1 | A granted refresh sequence is in progress |

## Verification
The assertions assume nothing about when `ref_gnt` is raised or how long it is held, since the sequencer looks at it only in the idle state while a request is pending. They do assume that every timing parameter is at least 2 and that OWED_MAX is at least 1. The stimulus uses such values. It raises the grant once at a moment with no request, once right as a request appears, and once after the timer has overrun several intervals. Each grant is timed so that no interval tick falls inside the refresh burst, which keeps the expected refresh counts exact.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // pin code {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_PRE,
    ST_PRE_W,
    ST_IREF,
    ST_IREF_W,
    ST_MRS,
    ST_MRS_W,
    ST_IDLE,
    ST_RPRE,
    ST_RPRE_W,
    ST_RREF,
    ST_RREF_W
  } seq_st_e;

endpackage

// File: rtl/sdr_countdown.sv
module sdr_countdown #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= W'(RST_VAL);
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == 0);

endmodule

// File: rtl/sdr_refresh_tracker.sv
module sdr_refresh_tracker #(
  parameter int REF_CYC  = 1562,
  parameter int OWED_MAX = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              run,
  input  logic                              take,
  output logic [$clog2(OWED_MAX+1)-1:0]     owed
);

  localparam int RW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
  localparam int OW = $clog2(OWED_MAX + 1);

  logic [RW-1:0] ivl_q;
  logic          tick;
  logic [OW:0]   sum;

  assign tick = run && (ivl_q == RW'(REF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     ivl_q <= '0;
    else if (tick)  ivl_q <= '0;
    else if (run)   ivl_q <= ivl_q + 1'b1;
  end

  always_comb begin
    sum = {1'b0, owed} + (OW+1)'(tick) - (OW+1)'(take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    owed <= '0;
    else if (sum > (OW+1)'(OWED_MAX)) owed <= OW'(OWED_MAX);
    else                           owed <= sum[OW-1:0];
  end

  // R10
  owed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX));

  // R9
  take_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (owed != 0));

endmodule

// File: rtl/sdr_cmd_reg.sv
module sdr_cmd_reg
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdr_cmd_e          cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);

  sdr_cmd_e cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
    end else begin
      cmd_q <= cmd_in;
      addr  <= addr_in;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int          CLK_MHZ   = 100,
  parameter int          ADDR_W    = 12,
  parameter int          A10_BIT   = 10,
  parameter int          PAUSE_CYC = 200 * CLK_MHZ,
  parameter int          T_RP      = 3,
  parameter int          T_RC      = 8,
  parameter int          T_MRD     = 2,
  parameter int          INIT_REFS = 8,
  parameter int          REF_CYC   = (64000 * CLK_MHZ) / 4096,
  parameter int          OWED_MAX  = 2,
  parameter logic [11:0] MODE_WORD = 12'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_cke,
  output logic              ready,
  output logic              ref_req,
  output logic              ref_busy
);

  localparam int CW = $clog2(PAUSE_CYC + T_RP + T_RC + T_MRD + 1);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam int OW = $clog2(OWED_MAX + 1);
  localparam int GW = $clog2(T_RC + 1);
  localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << A10_BIT;

  seq_st_e         st_q, st_n;
  logic            ld;
  logic [CW-1:0]   ld_val;
  logic            t_zero;
  logic [IW-1:0]   iref_q;
  logic [OW-1:0]   owed;
  logic            take;
  sdr_cmd_e        cmd_n;
  logic [ADDR_W-1:0] addr_n;

  sdr_countdown #(.W(CW), .RST_VAL(PAUSE_CYC - 1)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(t_zero)
  );

  sdr_refresh_tracker #(.REF_CYC(REF_CYC), .OWED_MAX(OWED_MAX)) u_track (
    .clk(clk), .rst_n(rst_n), .run(ready), .take(take), .owed(owed)
  );

  always_comb begin
    st_n   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    take   = 1'b0;
    unique case (st_q)
      ST_PAUSE:  if (t_zero) st_n = ST_PRE;
      ST_PRE:    begin st_n = ST_PRE_W;  ld = 1'b1; ld_val = CW'(T_RP - 2);  end
      ST_PRE_W:  if (t_zero) st_n = ST_IREF;
      ST_IREF:   begin st_n = ST_IREF_W; ld = 1'b1; ld_val = CW'(T_RC - 2);  end
      ST_IREF_W: if (t_zero) st_n = (iref_q == IW'(INIT_REFS)) ? ST_MRS : ST_IREF;
      ST_MRS:    begin st_n = ST_MRS_W;  ld = 1'b1; ld_val = CW'(T_MRD - 2); end
      ST_MRS_W:  if (t_zero) st_n = ST_IDLE;
      ST_IDLE:   if ((owed != 0) && ref_gnt) st_n = ST_RPRE;
      ST_RPRE:   begin st_n = ST_RPRE_W; ld = 1'b1; ld_val = CW'(T_RP - 2);  end
      ST_RPRE_W: if (t_zero) begin st_n = ST_RREF; take = 1'b1; end
      ST_RREF:   begin st_n = ST_RREF_W; ld = 1'b1; ld_val = CW'(T_RC - 2);  end
      ST_RREF_W: if (t_zero) begin
                   if (owed != 0) begin st_n = ST_RREF; take = 1'b1; end
                   else            st_n = ST_IDLE;
                 end
      default:   st_n = ST_PAUSE;
    endcase
  end

  always_comb begin
    cmd_n  = CMD_NOP;
    addr_n = '0;
    case (st_n)
      ST_PRE, ST_RPRE:  begin cmd_n = CMD_PRE; addr_n = PRE_ALL; end
      ST_IREF, ST_RREF: cmd_n = CMD_REF;
      ST_MRS:           begin cmd_n = CMD_MRS; addr_n = ADDR_W'(MODE_WORD); end
      default:          ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      iref_q <= '0;
      sd_cke <= 1'b0;
      ready  <= 1'b0;
    end else begin
      st_q   <= st_n;
      sd_cke <= 1'b1;
      if (st_n == ST_IREF) iref_q <= iref_q + 1'b1;
      if (st_n == ST_IDLE) ready <= 1'b1;
    end
  end

  sdr_cmd_reg #(.ADDR_W(ADDR_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_n), .addr_in(addr_n),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr)
  );

  assign ref_req  = (owed != 0) && (st_q == ST_IDLE);
  assign ref_busy = (st_q == ST_RPRE) || (st_q == ST_RPRE_W) ||
                    (st_q == ST_RREF) || (st_q == ST_RREF_W);

  // ---------------- checks on the pin stream ----------------
  logic [3:0]    pin_cmd;
  logic [3:0]    last_q;
  logic [GW-1:0] gap_q;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= CMD_NOP;
      gap_q  <= GW'(T_RC);
    end else begin
      if (pin_cmd != CMD_NOP) last_q <= pin_cmd;
      if (pin_cmd == CMD_REF)  gap_q <= GW'(1);
      else if (gap_q < GW'(T_RC)) gap_q <= gap_q + 1'b1;
    end
  end

  // R4
  mrs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_MRS) |-> $past(sd_cke));

  // R4
  mrs_nop_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_MRS) |=> (pin_cmd == CMD_NOP));

  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd != CMD_NOP) |-> (gap_q >= GW'(T_RC)));

  // R7
  banks_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_REF) |-> ((last_q == CMD_PRE) || (last_q == CMD_REF)));

  // R8
  req_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready);

  // R2
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_PRE) |-> sd_addr[A10_BIT]);

  // R9
  busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !ref_req);

endmodule

// File: tb/sdr_init_refresh_test.sv
module sdr_init_refresh_test;

  localparam int PAUSE = 40;
  localparam int TRP   = 2;
  localparam int TRC   = 5;
  localparam int TMRD  = 2;
  localparam int NREF  = 3;
  localparam int RCYC  = 150;
  localparam logic [11:0] MODE = 12'h032;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;

  // expected initialization stream: command, gap from previous, address
  localparam logic [3:0]  T_CMD [5] = '{C_PRE, C_REF, C_REF, C_REF, C_MRS};
  localparam int          T_GAP [5] = '{PAUSE, TRP, TRC, TRC, TRC};
  localparam logic [11:0] T_ADR [5] = '{12'h400, 12'h000, 12'h000, 12'h000, MODE};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, ready, ref_req, ref_busy;
  logic [11:0] addr;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  sdr_init_refresh #(
    .ADDR_W(12), .A10_BIT(10), .PAUSE_CYC(PAUSE), .T_RP(TRP), .T_RC(TRC),
    .T_MRD(TMRD), .INIT_REFS(NREF), .REF_CYC(RCYC), .OWED_MAX(2), .MODE_WORD(MODE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_addr(addr), .sd_cke(cke), .ready(ready), .ref_req(ref_req), .ref_busy(ref_busy)
  );

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic next_cmd(output logic [3:0] c, output int at, output logic [11:0] a);
    do @(negedge clk); while (pins() == C_NOP);
    c = pins(); at = cyc; a = addr;
  endtask

  task automatic wait_idle(output int at, output int extra);
    extra = 0;
    do begin
      @(negedge clk);
      if (pins() != C_NOP) extra++;
    end while (ref_busy);
    at = cyc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    logic [3:0] c; logic [11:0] a;
    int at, prev, mrs_at, rdy, pre_at, r1, r2, extra, idle_at, sent;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(pins() == C_NOP, "R1", "cmd in reset", pins(), C_NOP);
    chk(cke == 0, "R1", "cke in reset", cke, 0);
    chk(!ready && !ref_req && !ref_busy, "R1", "flags in reset",
        {ready, ref_req, ref_busy}, 0);
    rst_n = 1'b1;

    // R2 R3 R4 initialization stream walked from the table
    prev = 0; mrs_at = 0;
    for (int i = 0; i < 5; i++) begin
      string tag;
      tag = (i == 0) ? "R2" : (i == 4) ? "R4" : "R3";
      next_cmd(c, at, a);
      chk(c == T_CMD[i], tag, "command", c, T_CMD[i]);
      chk(at - prev == T_GAP[i], tag, "gap", at - prev, T_GAP[i]);
      chk(a == T_ADR[i], tag, "address", a, T_ADR[i]);
      if (i == 4) begin
        chk(cke == 1, "R4", "cke at mode set", cke, 1);
        chk(ready == 0, "R5", "ready at mode set", ready, 0);
        mrs_at = at;
      end
      prev = at;
    end

    @(negedge clk);
    chk(pins() == C_NOP, "R4", "cmd after mode set", pins(), C_NOP);
    while (cyc < mrs_at + TMRD - 1) @(negedge clk);
    chk(ready == 0, "R5", "ready early", ready, 0);
    @(negedge clk);
    chk(ready == 1, "R5", "ready rise", ready, 1);
    rdy = cyc;

    // R11 grant without request
    ref_gnt = 1'b1; sent = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pins() != C_NOP || ref_req) sent++;
    end
    ref_gnt = 1'b0;
    chk(sent == 0, "R11", "activity on idle grant", sent, 0);

    // R8 first request
    while (!ref_req) @(negedge clk);
    chk(cyc == rdy + RCYC, "R8", "first request cycle", cyc, rdy + RCYC);
    chk(ready == 1, "R5", "ready still high", ready, 1);

    // R9 single granted refresh
    ref_gnt = 1'b1;
    next_cmd(c, pre_at, a);
    ref_gnt = 1'b0;
    chk(c == C_PRE && a == 12'h400, "R9", "precharge-all on grant", c, C_PRE);
    chk(pre_at == rdy + RCYC + 1, "R9", "precharge cycle", pre_at, rdy + RCYC + 1);
    chk(ref_busy && !ref_req, "R9", "busy without request", {ref_busy, ref_req}, 2);
    next_cmd(c, r1, a);
    chk(c == C_REF && r1 - pre_at == TRP, "R9", "refresh after precharge", r1 - pre_at, TRP);
    wait_idle(idle_at, extra);
    chk(idle_at == r1 + TRC, "R9", "busy end", idle_at, r1 + TRC);
    chk(extra == 0, "R9", "extra commands", extra, 0);
    chk(ref_req == 0, "R8", "request cleared", ref_req, 0);

    // R10 overrun: three intervals pass with no grant
    while (cyc < rdy + 4 * RCYC + 20) @(negedge clk);
    chk(ref_req == 1, "R8", "request held pending", ref_req, 1);
    ref_gnt = 1'b1;
    next_cmd(c, pre_at, a);
    ref_gnt = 1'b0;
    chk(c == C_PRE, "R10", "precharge", c, C_PRE);
    next_cmd(c, r1, a);
    chk(c == C_REF && r1 - pre_at == TRP, "R10", "first catch-up refresh", r1 - pre_at, TRP);
    next_cmd(c, r2, a);
    chk(c == C_REF && r2 - r1 == TRC, "R10", "second catch-up refresh", r2 - r1, TRC);
    wait_idle(idle_at, extra);
    chk(extra == 0 && idle_at == r2 + TRC, "R10", "burst of exactly two", extra, 0);
    chk(ref_req == 0, "R10", "request after catch-up", ref_req, 0);

    // R8 interval timer runs freely through the grants
    while (!ref_req) @(negedge clk);
    chk(cyc == rdy + 5 * RCYC, "R8", "free-running period", cyc, rdy + 5 * RCYC);

    // R1 R2 reset in operation restarts the sequence
    rst_n = 1'b0;
    @(negedge clk);
    chk(pins() == C_NOP && !cke && !ready && !ref_req, "R1", "mid-run reset",
        {pins(), cke, ready, ref_req}, {C_NOP, 3'b000});
    rst_n = 1'b1;
    next_cmd(c, at, a);
    chk(c == C_PRE && at == PAUSE, "R2", "pause after second reset", at, PAUSE);

    finish_run();
  end

endmodule